// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers single-cycle event strobes from a set of channels. Each channel holds several eight-bit status registers, each with its own mask register. A strobe sets its status bit. An unmasked bit that is set is pending. Pending bits roll up into two pointer levels. The first level is a per-channel pointer with one bit per status register. The second is a global pointer with one bit per channel. A single registered, active-low interrupt line is driven while anything is pending.

Service software reads the global pointer to find a channel, then reads that channel's pointer to find a register, then reads the register itself. Reading a status register returns its visible pending bits and clears them. While any read is on the bus, status registers take no new events. Those events wait in a per-register holding stage and merge at the first cycle without a read, so an event that lands together with the clearing read is not lost. Bit positions that a parameter marks as unimplemented are treated as reserved. Their mask bits always read one, and events on them are dropped.

Address layout: the upper address bits pick the channel, and the low four bits pick the register. Values 0 to N_REG-1 select status registers, 8 to 8+N_REG-1 select mask registers, 14 selects the global pointer (channel field ignored), and 15 selects the channel pointer. Any other value reads as zero. N_REG may be at most 6, and the data width must be at least the channel count.

Top module: `irq_aggregator`

## Requirements
- R1: A masked status bit never sets a pointer bit or drives the interrupt, and it reads back as zero from its status register.
- R2: Channel pointer bit r (address low nibble 15) reads 1 exactly when status register r of that channel holds an unmasked set bit, zero-extended to the data width.
- R3: Global pointer bit c (low nibble 14) reads 1 exactly when channel c's pointer is nonzero.
- R4: A read asserted on bus_re at one clock edge presents its data on bus_rdata after that edge. The data holds until the next read.
- R5: Reading a status register returns its unmasked pending bits and clears only those bits. Masked set bits are kept. Other registers in the channel keep their pointer bits.
- R6: irq_n is registered. After each edge it equals the inverse of "global pointer nonzero" as it stood before that edge.
- R7: An event strobed while bus_re is high does not reach the status register until the first edge at which bus_re is low.
- R8: Mask bits at reserved positions (by default bits 7:6 of status register 5) always read 1 whatever is written, and events on those positions never become pending.
- R9: An event that lands on the same edge as the clearing read of its register is not returned by that read, and it is pending afterwards.
- R10: After reset all status bits are zero, every mask bit reads 1 (0xFF), both pointers read zero, and irq_n is 1.
- R11: Writes to pointer and status addresses have no effect.
- R12: Writing a zero to the mask bit of an already-set status bit makes the pointers show it after that write edge, and irq_n falls one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_CH*N_REG*W | Event strobes, bit (c*N_REG+r)*W+b for channel c, register r, bit b |
| bus_addr | input | CH_W+4 | Register address: channel field above a 4-bit register select |
| bus_wdata | input | W | Write data (mask registers only) |
| bus_we | input | 1 | Write strobe, ignored when bus_re is high |
| bus_re | input | 1 | Read strobe, one read per cycle it is high |
| bus_rdata | output | W | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The hardest situations to reach are the ones where timing decides the outcome. One is an event that arrives in the very cycle its register is being cleared. Another is an event held back across a burst of back-to-back reads. The bench drives the strobe and the read strobe on the same falling edge and keeps the read asserted for several cycles. It then tracks irq_n edge by edge to show the deferred event merges only after the bus goes quiet. A full sweep over every channel and register with computed patterns, including one made only of reserved bits, covers the rollup and clear paths.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SEL_W     = 4;
  localparam int MASK_BASE = 8;
  localparam int SEL_GPTR  = 14;
  localparam int SEL_CPTR  = 15;
endpackage

// File: rtl/irq_stat_cell.sv
module irq_stat_cell #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         rd_busy,
  input  logic         rd_clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] stat_q, hold_q, evt_v;

  assign evt_v = evt & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      hold_q <= '0;
      mask_q <= '1;
    end else begin
      if (mask_we) mask_q <= mask_wdata | ~IMPL;
      if (rd_busy) begin
        // bus busy: park new events, clear visible bits on a hit
        hold_q <= hold_q | evt_v;
        if (rd_clr) stat_q <= stat_q & mask_q;
      end else begin
        stat_q <= stat_q | hold_q | evt_v;
        hold_q <= '0;
      end
    end
  end

  assign pend = stat_q & ~mask_q;
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int N_REG = 6,
  parameter int W     = 8,
  parameter logic [N_REG*W-1:0] IMPL = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_REG*W-1:0] evt,
  input  logic               rd_busy,
  input  logic [N_REG-1:0]   rd_clr,
  input  logic [N_REG-1:0]   mask_we,
  input  logic [W-1:0]       wdata,
  output logic [N_REG*W-1:0] pend,
  output logic [N_REG*W-1:0] mask,
  output logic [N_REG-1:0]   ptr
);
  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    irq_stat_cell #(.W(W), .IMPL(IMPL[r*W +: W])) u_cell (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt[r*W +: W]),
      .rd_busy   (rd_busy),
      .rd_clr    (rd_clr[r]),
      .mask_we   (mask_we[r]),
      .mask_wdata(wdata),
      .pend      (pend[r*W +: W]),
      .mask_q    (mask[r*W +: W])
    );
    assign ptr[r] = |pend[r*W +: W];
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_REG = 6,
  parameter int W     = 8,
  parameter logic [N_REG*W-1:0] IMPL = {2'b00, {(N_REG*W-2){1'b1}}},
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CH*N_REG*W-1:0] evt_i,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [W-1:0]            bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_re,
  output logic [W-1:0]            bus_rdata,
  output logic                    irq_n
);
  logic [CH_W-1:0]    ch_idx;
  logic [SEL_W-1:0]   sel;
  logic [N_REG*W-1:0] pend_all [N_CH];
  logic [N_REG*W-1:0] mask_all [N_CH];
  logic [N_REG-1:0]   ptr_all  [N_CH];
  logic [N_CH-1:0]    gptr;
  logic [W-1:0]       rd_next;

  assign ch_idx = bus_addr[ADDR_W-1:SEL_W];
  assign sel    = bus_addr[SEL_W-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_REG-1:0] rd_clr, mask_we;
    for (genvar r = 0; r < N_REG; r++) begin : g_dec
      assign rd_clr[r]  = bus_re && (ch_idx == CH_W'(c)) && (sel == SEL_W'(r));
      assign mask_we[r] = bus_we && !bus_re && (ch_idx == CH_W'(c))
                          && (sel == SEL_W'(MASK_BASE + r));
    end
    irq_channel #(.N_REG(N_REG), .W(W), .IMPL(IMPL)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_i[c*N_REG*W +: N_REG*W]),
      .rd_busy(bus_re),
      .rd_clr (rd_clr),
      .mask_we(mask_we),
      .wdata  (bus_wdata),
      .pend   (pend_all[c]),
      .mask   (mask_all[c]),
      .ptr    (ptr_all[c])
    );
    assign gptr[c] = |ptr_all[c];
  end

  always_comb begin
    rd_next = '0;
    if (sel == SEL_W'(SEL_GPTR)) rd_next = W'(gptr);
    for (int c = 0; c < N_CH; c++) begin
      if (ch_idx == CH_W'(c)) begin
        if (sel == SEL_W'(SEL_CPTR)) rd_next = W'(ptr_all[c]);
        for (int r = 0; r < N_REG; r++) begin
          if (sel == SEL_W'(r))             rd_next = pend_all[c][r*W +: W];
          if (sel == SEL_W'(MASK_BASE + r)) rd_next = mask_all[c][r*W +: W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      if (bus_re) bus_rdata <= rd_next;
      irq_n <= ~|gptr;
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_REG = 6,
  parameter int W     = 8,
  parameter logic [N_REG*W-1:0] IMPL = '1,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_re,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_rdata,
  input logic              irq_n,
  input logic [N_CH-1:0]   gptr
);
  logic [SEL_W-1:0] sel;
  assign sel = bus_addr[SEL_W-1:0];

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|$past(gptr)));

  p_no_rise_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_we) |=> ((gptr & ~$past(gptr)) == '0));

  p_reset_quiet_r10: assert property (@(posedge clk)
    $fell(rst) |-> (irq_n && (gptr == '0)));

  for (genvar r = 0; r < N_REG; r++) begin : g_rsvd
    localparam logic [W-1:0] RSV = ~IMPL[r*W +: W];
    p_rsvd_mask_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_re && (sel == SEL_W'(MASK_BASE + r))) |=> ((bus_rdata & RSV) == RSV));
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_CH(N_CH), .N_REG(N_REG), .W(W), .IMPL(IMPL), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_re(bus_re), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_n(irq_n), .gptr(gptr)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  localparam int NC = 8, NR = 6, W = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic [NC*NR*W-1:0] evt_i = '0;
  logic [6:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [W-1:0] bus_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  logic [W-1:0] d;

  always #2.5 clk = ~clk;

  irq_aggregator dut (.clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_n(irq_n));

  function automatic logic [6:0] a(int ch, int s);
    return {3'(ch), 4'(s)};
  endfunction
  function automatic logic [W-1:0] impl(int r);
    return (r == 5) ? 8'h3F : 8'hFF;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic rd(logic [6:0] ad, output logic [W-1:0] q);
    @(negedge clk); bus_re = 1'b1; bus_addr = ad;
    @(negedge clk); bus_re = 1'b0; q = bus_rdata;
  endtask
  task automatic wr(logic [6:0] ad, logic [W-1:0] v);
    @(negedge clk); bus_we = 1'b1; bus_addr = ad; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic pulse(int ch, int r, logic [W-1:0] v);
    @(negedge clk); evt_i[(ch*NR+r)*W +: W] = v;
    @(negedge clk); evt_i = '0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4); rst = 1'b0; idle(1);
    // R10 reset state
    check("R10 irq_n", irq_n, 1);
    rd(a(0, 14), d); check("R10 gptr", d, 0);
    rd(a(2, 8), d);  check("R10 mask0", d, 8'hFF);
    rd(a(7, 13), d); check("R10 mask5", d, 8'hFF);
    // R1 masked event hidden, R12 unmask raises it
    pulse(3, 2, 8'h01); idle(1);
    check("R1 irq_n masked", irq_n, 1);
    rd(a(3, 2), d);  check("R1 status hidden", d, 0);
    rd(a(3, 15), d); check("R1 cptr masked", d, 0);
    wr(a(3, 10), 8'hFE);
    check("R12 irq_n not yet", irq_n, 1);
    idle(1); check("R12 irq_n falls", irq_n, 0);
    rd(a(3, 15), d); check("R12 cptr", d, 8'h04);
    rd(a(3, 2), d);  check("R12 status", d, 8'h01);
    // R8 reserved mask bits stay set
    wr(a(0, 13), 8'h00);
    rd(a(0, 13), d); check("R8 rsvd mask", d, 8'hC0);
    // unmask all
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) wr(a(c, 8 + r), 8'h00);
    idle(1); check("R5 idle irq", irq_n, 1);
    // sweep: R2, R3, R4, R5, R6, R8
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) begin
        logic [W-1:0] p, e;
        p = ((c*8 + r)*29 + 5) & 8'hFF;
        if (r == 5) p = p | 8'hC0;
        if (c == 0 && r == 5) p = 8'hC0;
        e = p & impl(r);
        pulse(c, r, p); idle(1);
        check("R6 irq low", irq_n, (e != 0) ? 0 : 1);
        rd(a((c + 1) % NC, 14), d); check("R3 gptr", d, (e != 0) ? (8'h1 << c) : 0);
        rd(a(c, 15), d); check("R2 cptr", d, (e != 0) ? (8'h1 << r) : 0);
        rd(a(c, r), d);  check("R4 R8 status", d, e);
        rd(a(c, r), d);  check("R5 cleared", d, 0);
        idle(1); check("R6 irq released", irq_n, 1);
      end
    // R11 writes to status/pointers ignored
    pulse(1, 0, 8'h00);
    wr(a(1, 0), 8'hFF); wr(a(1, 15), 8'hFF); wr(a(1, 14), 8'hFF);
    idle(1); check("R11 irq", irq_n, 1);
    rd(a(1, 14), d); check("R11 gptr", d, 0);
    rd(a(1, 0), d);  check("R11 status", d, 0);
    // R9 collision with clearing read
    pulse(2, 1, 8'h01); idle(1);
    @(negedge clk); bus_re = 1'b1; bus_addr = a(2, 1); evt_i[(2*NR+1)*W +: W] = 8'h02;
    @(negedge clk); bus_re = 1'b0; evt_i = '0;
    check("R9 read old", bus_rdata, 8'h01);
    rd(a(2, 1), d); check("R9 kept", d, 8'h02);
    idle(1); check("R9 irq", irq_n, 1);
    // R7 deferred across a read burst
    @(negedge clk); bus_re = 1'b1; bus_addr = a(0, 14); evt_i[(4*NR+3)*W +: W] = 8'h20;
    @(negedge clk); evt_i = '0; check("R7 hold e1", irq_n, 1);
    @(negedge clk); check("R7 hold e2", irq_n, 1);
    @(negedge clk); bus_re = 1'b0; check("R7 hold e3", irq_n, 1);
    check("R7 gptr read", bus_rdata, 0);
    @(negedge clk); check("R7 merge edge", irq_n, 1);
    @(negedge clk); check("R7 irq after", irq_n, 0);
    rd(a(4, 3), d); check("R7 status", d, 8'h20);
    // R5 partial clear, masked bits kept
    pulse(6, 0, 8'h81); pulse(6, 4, 8'h10);
    rd(a(6, 15), d); check("R5 cptr both", d, 8'h11);
    rd(a(6, 0), d);  check("R5 status0", d, 8'h81);
    rd(a(6, 15), d); check("R5 cptr left", d, 8'h10);
    check("R5 irq held", irq_n, 0);
    wr(a(6, 12), 8'h10); idle(1);
    rd(a(6, 4), d);  check("R1 masked read", d, 0);
    idle(1); check("R1 irq masked", irq_n, 1);
    wr(a(6, 12), 8'h00);
    rd(a(6, 15), d); check("R5 masked kept", d, 8'h10);
    rd(a(6, 4), d);  check("R5 status4", d, 8'h10);
    // R3 two channels
    pulse(1, 0, 8'h01); pulse(7, 5, 8'h02);
    rd(a(0, 14), d); check("R3 two ch", d, 8'h82);
    rd(a(1, 0), d);
    rd(a(0, 14), d); check("R3 one ch", d, 8'h80);
    check("R6 still low", irq_n, 0);
    rd(a(7, 5), d); idle(1);
    check("R6 all clear", irq_n, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule